// File: doc/BRIEF.md
# Dual Radix-2 Complex Butterfly with Transform Modes

This block is the arithmetic core of a stage-by-stage fast Fourier transform engine. Two butterfly lanes run side by side under one set of mode selects. Each lane takes two complex operands, a twiddle factor and two reference samples, and returns a high-path and a low-path result. The butterfly is decimation-in-frequency: the high path is the sum and the low path is the difference rotated by the twiddle. An external sequencer calls the block once per operand pair for every stage of the transform. It marks the first and last stage with two flags.

One forward butterfly serves four uses. The selects are written as {A,B,C}. 000 runs a forward transform. 010 runs an inverse transform, built by exchanging the real and imaginary parts at the transform input and output and by halving every stage. 001 runs a forward transform and then multiplies the result by a reference signal after its last stage. 110 multiplies the input by a reference signal and then runs an inverse transform. All values are Q1.15 fixed point. A complex word carries the real part in bits 31:16 and the imaginary part in bits 15:0.

Top module: `bfly_dual_unit`

## Requirements
- R1: `outValid` goes high exactly three clock cycles after `inValid` is sampled high, and the results for that input are on the outputs in that same cycle.
- R2: With all selects low, `hiOut` = sat(a+b) and `loOut` = cmul(sat(a−b), twid), taken part by part. cmul is the Q1.15 complex product: each 32-bit sum of products has 2^14 added and is then shifted right arithmetically by 15. Real part is in bits 31:16 and imaginary part in bits 15:0.
- R3: Every sum, difference and product saturates to the range −32768..32767. This includes (−1)·(−1), which gives 32767.
- R4: With B high, the sum and the difference are each halved as (x+1)>>>1 before the twiddle multiply. This applies on every stage.
- R5: With B high and `firstStage` high, both inputs have their real and imaginary parts exchanged, after any reference multiply. With `firstStage` low, no exchange takes place.
- R6: With B high and `lastStage` high, both results have their real and imaginary parts exchanged. With B low, `lastStage` never causes an exchange.
- R7: With A high and `firstStage` high, input a is multiplied by `refHi` and input b by `refLo` (cmul) before the butterfly. With `firstStage` low, A has no effect.
- R8: With C high and `lastStage` high, the high result is multiplied by `refHi` and the low result by `refLo` after the butterfly, before any output exchange. Otherwise C has no effect.
- R9: The two lanes share the selects and stage flags. Each lane computes only from its own operands, twiddle and references.
- R10: While `rstN` is low, `outValid` is low and every result output is zero.
- R11: While `outValid` is low, the result outputs keep the last valid result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operands on this cycle are to be processed |
| selA | input | 1 | Multiply by reference before the butterfly (first stage) |
| selB | input | 1 | Inverse transform: halving and IQ exchange |
| selC | input | 1 | Multiply by reference after the butterfly (last stage) |
| firstStage | input | 1 | Operands belong to the first stage |
| lastStage | input | 1 | Operands belong to the last stage |
| opA0 | input | 32 | Lane 0 upper operand |
| opB0 | input | 32 | Lane 0 lower operand |
| twid0 | input | 32 | Lane 0 twiddle factor |
| refHi0 | input | 32 | Lane 0 reference for operand a / high result |
| refLo0 | input | 32 | Lane 0 reference for operand b / low result |
| opA1 | input | 32 | Lane 1 upper operand |
| opB1 | input | 32 | Lane 1 lower operand |
| twid1 | input | 32 | Lane 1 twiddle factor |
| refHi1 | input | 32 | Lane 1 reference for operand a / high result |
| refLo1 | input | 32 | Lane 1 reference for operand b / low result |
| outValid | output | 1 | Results are valid |
| hiOut0 | output | 32 | Lane 0 high-path result |
| loOut0 | output | 32 | Lane 0 low-path result |
| hiOut1 | output | 32 | Lane 1 high-path result |
| loOut1 | output | 32 | Lane 1 low-path result |

## Verification
The hardest situations to reach are the ones that depend on where a beat sits within a transform. These are the input exchange and pre-multiply on the first stage, and the output exchange and post-multiply on the last. The same select code must then leave a middle-stage beat untouched. The stimulus table therefore pairs each mode with its first-stage, last-stage, middle-stage and single-stage (both flags set) variants. It streams the beats back to back, so that the per-stage flags must travel through the pipeline beside their own data. Saturation corners (sum overflow and the −1 times −1 product) and odd values that expose the halving's rounding are placed in the same stream. Lane 1 receives the operands of lane 0 exchanged, so the two lanes always differ.

// File: rtl/bfly_pkg.sv
`timescale 1ns/1ps
package bfly_pkg;

  // Per-stage strobes from control to datapath; suffix gives pipeline stage.
  typedef struct packed {
    logic ld1;       // stage 1 captures operands
    logic preMul1;   // multiply inputs by references
    logic swapIn1;   // exchange IQ of inputs
    logic ld2;       // stage 2 captures butterfly results
    logic halve2;    // halve sum and difference
    logic ld3;       // stage 3 captures final results
    logic postMul3;  // multiply results by references
    logic swapOut3;  // exchange IQ of results
  } bflyStrobe_t;

  localparam int PIPE_DEPTH = 3;

endpackage

// File: rtl/bfly_ctrl.sv
`timescale 1ns/1ps
module bfly_ctrl
  import bfly_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        selPre,
  input  logic        selInv,
  input  logic        selPost,
  input  logic        firstStage,
  input  logic        lastStage,
  output bflyStrobe_t strb,
  output logic        outValid
);

  logic v1, halve1, post1, swap1;
  logic v2, post2, swap2;
  logic v3;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      v1     <= 1'b0;
      halve1 <= 1'b0;
      post1  <= 1'b0;
      swap1  <= 1'b0;
      v2     <= 1'b0;
      post2  <= 1'b0;
      swap2  <= 1'b0;
      v3     <= 1'b0;
    end else begin
      v1     <= inValid;
      halve1 <= selInv;
      post1  <= selPost & lastStage;
      swap1  <= selInv & lastStage;
      v2     <= v1;
      post2  <= post1;
      swap2  <= swap1;
      v3     <= v2;
    end
  end

  always_comb begin
    strb.ld1      = inValid;
    strb.preMul1  = selPre & firstStage;
    strb.swapIn1  = selInv & firstStage;
    strb.ld2      = v1;
    strb.halve2   = halve1;
    strb.ld3      = v2;
    strb.postMul3 = post2;
    strb.swapOut3 = swap2;
  end

  assign outValid = v3;

endmodule

// File: rtl/bfly_lane.sv
`timescale 1ns/1ps
module bfly_lane
  import bfly_pkg::*;
#(
  parameter int W = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  bflyStrobe_t   strb,
  input  logic [2*W-1:0] opA,
  input  logic [2*W-1:0] opB,
  input  logic [2*W-1:0] twid,
  input  logic [2*W-1:0] refHi,
  input  logic [2*W-1:0] refLo,
  output logic [2*W-1:0] hiOut,
  output logic [2*W-1:0] loOut
);

  localparam int CW = 2 * W;
  localparam int EW = 2 * W + 2;
  typedef logic signed [EW-1:0] wide_t;
  localparam wide_t MAXV = {{(W+3){1'b0}}, {(W-1){1'b1}}};
  localparam wide_t MINV = {{(W+3){1'b1}}, {(W-1){1'b0}}};
  localparam wide_t RND  = {{(W+3){1'b0}}, 1'b1, {(W-2){1'b0}}};

  function automatic wide_t ext(input logic [W-1:0] c);
    return wide_t'($signed(c));
  endfunction

  function automatic logic [W-1:0] clampW(input wide_t x);
    if (x > MAXV)      return MAXV[W-1:0];
    else if (x < MINV) return MINV[W-1:0];
    else               return x[W-1:0];
  endfunction

  function automatic logic [CW-1:0] swapIq(input logic [CW-1:0] x);
    return {x[W-1:0], x[CW-1:W]};
  endfunction

  // Q1.15 complex product, round half up, saturate
  function automatic logic [CW-1:0] cmulQ(input logic [CW-1:0] x, input logic [CW-1:0] y);
    wide_t xr, xi, yr, yi, re, im;
    xr = ext(x[CW-1:W]);
    xi = ext(x[W-1:0]);
    yr = ext(y[CW-1:W]);
    yi = ext(y[W-1:0]);
    re = ((xr * yr) - (xi * yi) + RND) >>> (W - 1);
    im = ((xr * yi) + (xi * yr) + RND) >>> (W - 1);
    return {clampW(re), clampW(im)};
  endfunction

  function automatic logic [W-1:0] combine(input logic [W-1:0] p, input logic [W-1:0] q,
                                           input logic sub, input logic halve);
    wide_t s;
    s = sub ? (ext(p) - ext(q)) : (ext(p) + ext(q));
    if (halve) s = (s + wide_t'(1)) >>> 1;
    return clampW(s);
  endfunction

  // ---- stage 1: optional reference multiply, then optional IQ exchange
  logic [CW-1:0] aPre, bPre, aIn, bIn;
  logic [CW-1:0] a1, b1, tw1, rh1, rl1;

  always_comb begin
    aPre = strb.preMul1 ? cmulQ(opA, refHi) : opA;
    bPre = strb.preMul1 ? cmulQ(opB, refLo) : opB;
    aIn  = strb.swapIn1 ? swapIq(aPre) : aPre;
    bIn  = strb.swapIn1 ? swapIq(bPre) : bPre;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      a1  <= '0;
      b1  <= '0;
      tw1 <= '0;
      rh1 <= '0;
      rl1 <= '0;
    end else if (strb.ld1) begin
      a1  <= aIn;
      b1  <= bIn;
      tw1 <= twid;
      rh1 <= refHi;
      rl1 <= refLo;
    end
  end

  // ---- stage 2: sum, difference (optionally halved), twiddle rotation
  logic [CW-1:0] sumC, diffC, rotC;
  logic [CW-1:0] hi2, lo2, rh2, rl2;

  always_comb begin
    sumC  = {combine(a1[CW-1:W], b1[CW-1:W], 1'b0, strb.halve2),
             combine(a1[W-1:0],  b1[W-1:0],  1'b0, strb.halve2)};
    diffC = {combine(a1[CW-1:W], b1[CW-1:W], 1'b1, strb.halve2),
             combine(a1[W-1:0],  b1[W-1:0],  1'b1, strb.halve2)};
    rotC  = cmulQ(diffC, tw1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hi2 <= '0;
      lo2 <= '0;
      rh2 <= '0;
      rl2 <= '0;
    end else if (strb.ld2) begin
      hi2 <= sumC;
      lo2 <= rotC;
      rh2 <= rh1;
      rl2 <= rl1;
    end
  end

  // ---- stage 3: optional reference multiply, then optional IQ exchange
  logic [CW-1:0] hiPost, loPost;

  always_comb begin
    hiPost = strb.postMul3 ? cmulQ(hi2, rh2) : hi2;
    loPost = strb.postMul3 ? cmulQ(lo2, rl2) : lo2;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiOut <= '0;
      loOut <= '0;
    end else if (strb.ld3) begin
      hiOut <= strb.swapOut3 ? swapIq(hiPost) : hiPost;
      loOut <= strb.swapOut3 ? swapIq(loPost) : loPost;
    end
  end

endmodule

// File: rtl/bfly_dual_unit.sv
`timescale 1ns/1ps
module bfly_dual_unit
  import bfly_pkg::*;
#(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           inValid,
  input  logic           selA,
  input  logic           selB,
  input  logic           selC,
  input  logic           firstStage,
  input  logic           lastStage,
  input  logic [2*W-1:0] opA0,
  input  logic [2*W-1:0] opB0,
  input  logic [2*W-1:0] twid0,
  input  logic [2*W-1:0] refHi0,
  input  logic [2*W-1:0] refLo0,
  input  logic [2*W-1:0] opA1,
  input  logic [2*W-1:0] opB1,
  input  logic [2*W-1:0] twid1,
  input  logic [2*W-1:0] refHi1,
  input  logic [2*W-1:0] refLo1,
  output logic           outValid,
  output logic [2*W-1:0] hiOut0,
  output logic [2*W-1:0] loOut0,
  output logic [2*W-1:0] hiOut1,
  output logic [2*W-1:0] loOut1
);

  localparam int LANES = 2;
  localparam int CW = 2 * W;

  bflyStrobe_t strb;

  logic [CW-1:0] laneA  [LANES];
  logic [CW-1:0] laneB  [LANES];
  logic [CW-1:0] laneTw [LANES];
  logic [CW-1:0] laneRh [LANES];
  logic [CW-1:0] laneRl [LANES];
  logic [CW-1:0] laneHi [LANES];
  logic [CW-1:0] laneLo [LANES];

  assign laneA[0]  = opA0;   assign laneA[1]  = opA1;
  assign laneB[0]  = opB0;   assign laneB[1]  = opB1;
  assign laneTw[0] = twid0;  assign laneTw[1] = twid1;
  assign laneRh[0] = refHi0; assign laneRh[1] = refHi1;
  assign laneRl[0] = refLo0; assign laneRl[1] = refLo1;

  bfly_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .selPre     (selA),
    .selInv     (selB),
    .selPost    (selC),
    .firstStage (firstStage),
    .lastStage  (lastStage),
    .strb       (strb),
    .outValid   (outValid)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    bfly_lane #(.W(W)) u_lane (
      .clk   (clk),
      .rstN  (rstN),
      .strb  (strb),
      .opA   (laneA[g]),
      .opB   (laneB[g]),
      .twid  (laneTw[g]),
      .refHi (laneRh[g]),
      .refLo (laneRl[g]),
      .hiOut (laneHi[g]),
      .loOut (laneLo[g])
    );
  end

  assign hiOut0 = laneHi[0];
  assign loOut0 = laneLo[0];
  assign hiOut1 = laneHi[1];
  assign loOut1 = laneLo[1];

endmodule

// File: rtl/bfly_dual_checker.sv
`timescale 1ns/1ps
module bfly_dual_checker #(
  parameter int W = 16
) (
  input logic           clk,
  input logic           rstN,
  input logic           inValid,
  input logic           outValid,
  input logic [2*W-1:0] opA0,
  input logic [2*W-1:0] opB0,
  input logic [2*W-1:0] twid0,
  input logic [2*W-1:0] refHi0,
  input logic [2*W-1:0] refLo0,
  input logic [2*W-1:0] opA1,
  input logic [2*W-1:0] opB1,
  input logic [2*W-1:0] twid1,
  input logic [2*W-1:0] refHi1,
  input logic [2*W-1:0] refLo1,
  input logic [2*W-1:0] hiOut0,
  input logic [2*W-1:0] loOut0,
  input logic [2*W-1:0] hiOut1,
  input logic [2*W-1:0] loOut1
);

  // cycles since reset release, saturating at the pipeline depth
  logic [1:0] sinceRst;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 sinceRst <= 2'd0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  logic lanesMatch;
  assign lanesMatch = (opA0 == opA1) && (opB0 == opB1) && (twid0 == twid1) &&
                      (refHi0 == refHi1) && (refLo0 == refLo1);

  assert_latency_R1: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3) |-> (outValid == $past(inValid, 3)));

  assert_zero_twiddle_R2: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3 && $past(inValid, 3) && $past(twid0 == '0, 3)) |-> (loOut0 == '0));

  assert_lane_symmetry_R9: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3 && $past(inValid, 3) && $past(lanesMatch, 3))
      |-> (hiOut0 == hiOut1 && loOut0 == loOut1));

  assert_reset_clear_R10: assert property (@(posedge clk)
    !rstN |-> (!outValid && hiOut0 == '0 && loOut0 == '0 && hiOut1 == '0 && loOut1 == '0));

  assert_hold_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst != 2'd0 && !outValid)
      |-> ($stable(hiOut0) && $stable(loOut0) && $stable(hiOut1) && $stable(loOut1)));

endmodule

bind bfly_dual_unit bfly_dual_checker #(.W(W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .outValid (outValid),
  .opA0     (opA0),
  .opB0     (opB0),
  .twid0    (twid0),
  .refHi0   (refHi0),
  .refLo0   (refLo0),
  .opA1     (opA1),
  .opB1     (opB1),
  .twid1    (twid1),
  .refHi1   (refHi1),
  .refLo1   (refLo1),
  .hiOut0   (hiOut0),
  .loOut0   (loOut0),
  .hiOut1   (hiOut1),
  .loOut1   (loOut1)
);

// File: tb/bfly_dual_unit_bench.sv
`timescale 1ns/1ps
module bfly_dual_unit_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic selA = 1'b0, selB = 1'b0, selC = 1'b0;
  logic firstStage = 1'b0, lastStage = 1'b0;
  logic [31:0] opA0 = '0, opB0 = '0, twid0 = '0, refHi0 = '0, refLo0 = '0;
  logic [31:0] opA1 = '0, opB1 = '0, twid1 = '0, refHi1 = '0, refLo1 = '0;
  logic outValid;
  logic [31:0] hiOut0, loOut0, hiOut1, loOut1;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bfly_dual_unit u_bfly_dual_unit (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .selA(selA), .selB(selB), .selC(selC),
    .firstStage(firstStage), .lastStage(lastStage),
    .opA0(opA0), .opB0(opB0), .twid0(twid0), .refHi0(refHi0), .refLo0(refLo0),
    .opA1(opA1), .opB1(opB1), .twid1(twid1), .refHi1(refHi1), .refLo1(refLo1),
    .outValid(outValid), .hiOut0(hiOut0), .loOut0(loOut0),
    .hiOut1(hiOut1), .loOut1(loOut1)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [2:0]  mode;   // {A,B,C}
    logic        first;
    logic        last;
    logic [31:0] a, b, tw, rh, rl, eh, el;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    // R2 forward butterfly, first stage
    '{4'd2,  3'b000, 1'b1, 1'b0, 32'h1000_0400, 32'h0800_FC00, 32'h4000_0000, 32'h4000_0000, 32'h4000_0000, 32'h1800_0000, 32'h0400_0400},
    // R3 sum saturation, imaginary twiddle
    '{4'd3,  3'b000, 1'b0, 1'b0, 32'h7530_8AD0, 32'h2710_D8F0, 32'h0000_4000, 32'h4000_0000, 32'h4000_0000, 32'h7FFF_8000, 32'h2710_2710},
    // R3 product saturation (-1 * -1)
    '{4'd3,  3'b000, 1'b0, 1'b0, 32'hC000_0000, 32'h4000_0000, 32'h8000_0000, 32'h4000_0000, 32'h4000_0000, 32'h0000_0000, 32'h7FFF_0000},
    // R4 inverse middle stage, halving with odd and negative values
    '{4'd4,  3'b010, 1'b0, 1'b0, 32'h03E9_FFF9, 32'h07D0_0003, 32'h4000_0000, 32'h4000_0000, 32'h4000_0000, 32'h05DD_FFFE, 32'hFF07_FFFE},
    // R5 inverse first stage, input exchange
    '{4'd5,  3'b010, 1'b1, 1'b0, 32'h0064_012C, 32'h0032_FF9C, 32'h4000_0000, 32'h4000_0000, 32'h4000_0000, 32'h0064_004B, 32'h0064_000D},
    // R6 inverse last stage, output exchange
    '{4'd6,  3'b010, 1'b0, 1'b1, 32'h0258_00C8, 32'h00C8_FF9C, 32'h4000_0000, 32'h4000_0000, 32'h4000_0000, 32'h0032_0190, 32'h004B_0064},
    // R6 forward last stage, no exchange
    '{4'd6,  3'b000, 1'b0, 1'b1, 32'h0258_00C8, 32'h00C8_FF9C, 32'h4000_0000, 32'h4000_0000, 32'h4000_0000, 32'h0320_0064, 32'h00C8_0096},
    // R8 forward then reference multiply on last stage
    '{4'd8,  3'b001, 1'b0, 1'b1, 32'h2000_0000, 32'h0000_0000, 32'h4000_0000, 32'h0000_4000, 32'h4000_0000, 32'h0000_1000, 32'h0800_0000},
    // R8 reference multiply ignored off the last stage
    '{4'd8,  3'b001, 1'b0, 1'b0, 32'h2000_0000, 32'h0000_0000, 32'h4000_0000, 32'h0000_4000, 32'h4000_0000, 32'h2000_0000, 32'h1000_0000},
    // R7 reference multiply then inverse, first stage
    '{4'd7,  3'b110, 1'b1, 1'b0, 32'h2000_1000, 32'h0000_0000, 32'h4000_0000, 32'h4000_0000, 32'h4000_0000, 32'h0400_0800, 32'h0200_0400},
    // R7 pre-multiply ignored off the first stage
    '{4'd7,  3'b110, 1'b0, 1'b0, 32'h2000_1000, 32'h0000_0000, 32'h4000_0000, 32'h4000_0000, 32'h4000_0000, 32'h1000_0800, 32'h0800_0400},
    // R5 and R6 single-stage inverse, both exchanges
    '{4'd5,  3'b010, 1'b1, 1'b1, 32'h0064_012C, 32'h0032_FF9C, 32'h4000_0000, 32'h4000_0000, 32'h4000_0000, 32'h004B_0064, 32'h000D_0064}
  };

  // ---- independent model from the requirements (used for lane 1, R9)
  function automatic longint sx(input logic [15:0] v);
    return longint'($signed(v));
  endfunction

  function automatic logic [15:0] sat16(input longint v);
    if (v > 32767)  return 16'h7FFF;
    if (v < -32768) return 16'h8000;
    return v[15:0];
  endfunction

  function automatic logic [31:0] mulQ(input logic [31:0] x, input logic [31:0] y);
    longint re, im;
    re = sx(x[31:16]) * sx(y[31:16]) - sx(x[15:0]) * sx(y[15:0]);
    im = sx(x[31:16]) * sx(y[15:0]) + sx(x[15:0]) * sx(y[31:16]);
    return {sat16((re + 16384) >>> 15), sat16((im + 16384) >>> 15)};
  endfunction

  function automatic logic [15:0] reduce(input longint v, input bit halve);
    return halve ? sat16((v + 1) >>> 1) : sat16(v);
  endfunction

  function automatic logic [63:0] model(input vec_t v, input logic [31:0] a0, input logic [31:0] b0);
    logic [31:0] a, b, hi, d, lo;
    a = a0; b = b0;
    if (v.mode[2] && v.first) begin a = mulQ(a, v.rh); b = mulQ(b, v.rl); end
    if (v.mode[1] && v.first) begin a = {a[15:0], a[31:16]}; b = {b[15:0], b[31:16]}; end
    hi = {reduce(sx(a[31:16]) + sx(b[31:16]), v.mode[1]), reduce(sx(a[15:0]) + sx(b[15:0]), v.mode[1])};
    d  = {reduce(sx(a[31:16]) - sx(b[31:16]), v.mode[1]), reduce(sx(a[15:0]) - sx(b[15:0]), v.mode[1])};
    lo = mulQ(d, v.tw);
    if (v.mode[0] && v.last) begin hi = mulQ(hi, v.rh); lo = mulQ(lo, v.rl); end
    if (v.mode[1] && v.last) begin hi = {hi[15:0], hi[31:16]}; lo = {lo[15:0], lo[31:16]}; end
    return {hi, lo};
  endfunction

  task automatic chk(input int r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    inValid = 1'b1;
    {selA, selB, selC} = v.mode;
    firstStage = v.first; lastStage = v.last;
    opA0 = v.a; opB0 = v.b; opA1 = v.b; opB1 = v.a;
    twid0 = v.tw; twid1 = v.tw;
    refHi0 = v.rh; refHi1 = v.rh; refLo0 = v.rl; refLo1 = v.rl;
  endtask

  task automatic checkVec(input vec_t v);
    logic [63:0] m;
    m = model(v, v.b, v.a);
    chk(1, {31'b0, outValid}, 32'd1);        // R1 result arrives with valid
    chk(int'(v.req), hiOut0, v.eh);
    chk(int'(v.req), loOut0, v.el);
    chk(9, hiOut1, m[63:32]);                // R9 lane 1 on its own operands
    chk(9, loOut1, m[31:0]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(10, {31'b0, outValid}, 32'd0);
    chk(10, hiOut0, 32'd0);
    chk(10, loOut1, 32'd0);
    rstN = 1'b1;

    // streamed table, one beat per cycle
    for (int i = 0; i < NV + 3; i++) begin
      @(negedge clk);
      if (i >= 3) checkVec(VEC[i-3]);
      if (i < NV) drive(VEC[i]);
      else inValid = 1'b0;
    end

    // R11 outputs hold while idle
    repeat (2) begin
      @(negedge clk);
      chk(11, {31'b0, outValid}, 32'd0);
      chk(11, hiOut0, VEC[NV-1].eh);
      chk(11, loOut1, model(VEC[NV-1], VEC[NV-1].b, VEC[NV-1].a) >> 0);
    end

    // R1 isolated beat: exactly three cycles
    @(negedge clk); drive(VEC[0]);
    @(negedge clk); inValid = 1'b0; chk(1, {31'b0, outValid}, 32'd0);
    @(negedge clk); chk(1, {31'b0, outValid}, 32'd0);
    @(negedge clk); chk(1, {31'b0, outValid}, 32'd1); chk(1, hiOut0, VEC[0].eh);
    @(negedge clk); chk(1, {31'b0, outValid}, 32'd0); chk(11, loOut0, VEC[0].el);

    // R10 reset in mid-flight clears everything
    @(negedge clk); drive(VEC[1]);
    @(negedge clk); inValid = 1'b0;
    @(negedge clk); rstN = 1'b0;
    #1;
    chk(10, {31'b0, outValid}, 32'd0);
    chk(10, hiOut0, 32'd0);
    chk(10, loOut0, 32'd0);
    chk(10, hiOut1, 32'd0);
    @(negedge clk); rstN = 1'b1;
    repeat (4) @(negedge clk);
    chk(10, {31'b0, outValid}, 32'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog: actual=hung expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule